// File: doc/BRIEF.md
# Fieldbus Produced-Data Frame Transmitter

This block builds and shifts out the response frame that a fieldbus agent returns once a produce request has been accepted. A one-cycle start pulse arms it. It then holds the line quiet for a fixed bus-turnaround gap. After the gap it sends the frame as one bit stream, most significant bit of each byte first:

- two start bytes;
- a control byte;
- the payload bytes, taken from a local produce buffer;
- a 16-bit CRC;
- a closing byte.

A transmit-enable output frames the stream, and a one-clock done pulse marks the end.

Bit timing comes from a divider with three selectable periods, one for each line rate (fast, middle, slow). The payload is read through a simple synchronous byte-read port with one cycle of latency. Each payload byte is fetched while the byte before it is still on the line, so the bit stream has no gaps. Line encoding and the buffer memory sit outside the block.

Top module: `ptx_frame_tx`

## Requirements
- R1: The frame is sent as byte 0xA9, byte 0x6E, control byte 0x50, the payload bytes, CRC high byte, CRC low byte, closing byte 0xD4. Every byte goes out MSB first.
- R2: A start is accepted only when `len_i` lies in 2..124. A start with any other length is ignored: transmit-enable stays low, no done pulse and no buffer read.
- R3: Transmit-enable goes high on the TA_CYCLES-th rising clock edge after the edge that accepts the start pulse.
- R4: Each bit is held for exactly the divider period of the rate latched at start. Rate code 0 selects DIV_SLOW, 1 selects DIV_MID and 2 selects DIV_FAST. Transmit-enable stays high for exactly (len+6)*8 bit periods.
- R5: A start with rate code 3 is ignored: transmit-enable stays low, no done pulse and no buffer read.
- R6: The CRC uses polynomial 0x1021 with initial value 0xFFFF and no final inversion. It is computed MSB first over the control byte and the payload bytes, and it is sent high byte first.
- R7: The buffer is read at addresses 0..len-1, each exactly once and in ascending order. Each read is issued while transmit-enable is high. Read data is taken one cycle after `rd_en_o`.
- R8: `done_o` is high for exactly one clock, in the first cycle in which transmit-enable is low again. `sout_o` is low whenever transmit-enable is low.
- R9: A start pulse that arrives while a frame is waiting or being sent has no effect. The frame in progress is unchanged, and no second frame or done pulse follows.
- R10: After reset, `tx_en_o`, `sout_o`, `done_o` and `rd_en_o` are low. An unused state encoding returns the controller to idle with transmit-enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame |
| rate_i | input | 2 | Rate code: 0 slow, 1 middle, 2 fast, 3 illegal |
| len_i | input | LEN_W (7) | Payload byte count |
| rd_en_o | output | 1 | Buffer read strobe |
| rd_addr_o | output | ADDR_W (7) | Buffer byte address |
| rd_data_i | input | 8 | Buffer read data, valid one cycle after the strobe |
| sout_o | output | 1 | Serial bit stream |
| tx_en_o | output | 1 | High while frame bits are on the line |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check these rules on every cycle:
- the done pulse is exactly one clock long and comes as transmit-enable falls;
- the line is low whenever transmit-enable is low;
- the serial bit changes only on a bit-timer tick;
- buffer reads happen only inside a frame and only at legal addresses.

Other properties need the bench's directed scenarios: the exact turnaround length, the byte contents and order of whole frames, the CRC value, the total frame duration at each rate, the ascending read sequence, and the rejection of starts that are illegal or that arrive while busy.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_GAP  = 2'b01,
        ST_SEND = 2'b10
    } ptx_state_e;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'd0,
        RATE_MID  = 2'd1,
        RATE_FAST = 2'd2
    } ptx_rate_e;

    localparam logic [1:0] RATE_BAD = 2'd3;
    localparam int unsigned BYTE_W  = 8;

endpackage

// File: rtl/ptx_bit_timer.sv
module ptx_bit_timer #(
    parameter int unsigned DIV_SLOW = 1280,
    parameter int unsigned DIV_MID  = 40,
    parameter int unsigned DIV_FAST = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    import ptx_pkg::*;

    localparam int unsigned DIV_HI  = (DIV_SLOW > DIV_MID) ? DIV_SLOW : DIV_MID;
    localparam int unsigned DIV_MAX = (DIV_HI > DIV_FAST) ? DIV_HI : DIV_FAST;
    localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        case (rate_i)
            RATE_MID:  reload = CNT_W'(DIV_MID - 1);
            RATE_FAST: reload = CNT_W'(DIV_FAST - 1);
            default:   reload = CNT_W'(DIV_SLOW - 1);
        endcase
    end

    assign tick_o = run_i && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || cnt_q == '0) begin
            cnt_d = reload;
        end else begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ptx_gap_timer.sv
module ptx_gap_timer #(
    parameter int unsigned TA_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned TA_W = $clog2(TA_CYCLES + 1);

    logic [TA_W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TA_W'(TA_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ptx_crc16.sv
module ptx_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    always_comb begin
        logic [15:0] acc;
        logic        fb;
        acc = crc_i;
        for (int i = 7; i >= 0; i--) begin
            fb  = acc[15] ^ byte_i[i];
            acc = {acc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
        end
        crc_o = acc;
    end

endmodule

// File: rtl/ptx_frame_tx.sv
module ptx_frame_tx #(
    parameter int unsigned MAX_LEN    = 124,
    parameter int unsigned MIN_LEN    = 2,
    parameter int unsigned TA_CYCLES  = 400,
    parameter int unsigned DIV_SLOW   = 1280,
    parameter int unsigned DIV_MID    = 40,
    parameter int unsigned DIV_FAST   = 16,
    parameter logic [15:0] START_WORD = 16'hA96E,
    parameter logic [7:0]  CTRL_BYTE  = 8'h50,
    parameter logic [7:0]  END_BYTE   = 8'hD4,
    parameter logic [15:0] CRC_POLY   = 16'h1021,
    parameter logic [15:0] CRC_INIT   = 16'hFFFF,
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned ADDR_W    = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        rate_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              sout_o,
    output logic              tx_en_o,
    output logic              done_o
);
    import ptx_pkg::*;

    // index of a byte inside the frame; the longest frame has MAX_LEN + 6 bytes
    localparam int unsigned IDX_W  = $clog2(MAX_LEN + 6);
    localparam int unsigned HDR_N  = 3;   // start word + control byte
    localparam int unsigned TAIL_N = 3;   // CRC word + closing byte

    typedef struct packed {
        ptx_state_e        st;
        logic [1:0]        rate;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  idx;
        logic [2:0]        bit_n;
        logic [7:0]        shift;
        logic [7:0]        dbuf;
        logic              pend;
        logic [15:0]       crc;
        logic              rd_en;
        logic [ADDR_W-1:0] rd_addr;
        logic              tx_en;
        logic              done;
    } ptx_regs_t;

    ptx_regs_t r_d, r_q;

    logic             bit_tick;
    logic             gap_load;
    logic             gap_expired;
    logic             start_ok;
    logic [IDX_W-1:0] ld_idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] data_end;
    logic             ld_is_data;
    logic             ld_needs_rd;
    logic [7:0]       byte_sel;
    logic [15:0]      crc_next;

    ptx_bit_timer #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_MID  (DIV_MID),
        .DIV_FAST (DIV_FAST)
    ) u_bit_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st == ST_SEND),
        .rate_i (r_q.rate),
        .tick_o (bit_tick)
    );

    ptx_gap_timer #(
        .TA_CYCLES (TA_CYCLES)
    ) u_gap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (gap_load),
        .expired_o (gap_expired)
    );

    ptx_crc16 #(
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_i  (r_q.crc),
        .byte_i (byte_sel),
        .crc_o  (crc_next)
    );

    assign start_ok = start_i && (rate_i != RATE_BAD)
                   && (len_i >= LEN_W'(MIN_LEN)) && (len_i <= LEN_W'(MAX_LEN));

    assign data_end = IDX_W'(r_q.len) + IDX_W'(HDR_N - 1);
    assign last_idx = IDX_W'(r_q.len) + IDX_W'(HDR_N + TAIL_N - 1);
    assign ld_idx   = (r_q.st == ST_GAP) ? '0 : (r_q.idx + IDX_W'(1));

    // the byte loaded now is data, and the byte after it is data (needs prefetch)
    assign ld_is_data  = (ld_idx >= IDX_W'(HDR_N)) && (ld_idx <= data_end);
    assign ld_needs_rd = (ld_idx >= IDX_W'(HDR_N - 1)) && (ld_idx < data_end);

    always_comb begin
        if (ld_idx == IDX_W'(0)) begin
            byte_sel = START_WORD[15:8];
        end else if (ld_idx == IDX_W'(1)) begin
            byte_sel = START_WORD[7:0];
        end else if (ld_idx == IDX_W'(2)) begin
            byte_sel = CTRL_BYTE;
        end else if (ld_is_data) begin
            byte_sel = r_q.dbuf;
        end else if (ld_idx == data_end + IDX_W'(1)) begin
            byte_sel = r_q.crc[15:8];
        end else if (ld_idx == data_end + IDX_W'(2)) begin
            byte_sel = r_q.crc[7:0];
        end else begin
            byte_sel = END_BYTE;
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.rd_en = 1'b0;
        r_d.done  = 1'b0;
        r_d.pend  = r_q.rd_en;
        gap_load  = 1'b0;
        if (r_q.pend) begin
            r_d.dbuf = rd_data_i;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    r_d.st    = ST_GAP;
                    r_d.rate  = rate_i;
                    r_d.len   = len_i;
                    r_d.crc   = CRC_INIT;
                    r_d.idx   = '0;
                    r_d.bit_n = '0;
                    r_d.shift = '0;
                    gap_load  = 1'b1;
                end
            end

            ST_GAP: begin
                if (gap_expired) begin
                    r_d.st    = ST_SEND;
                    r_d.tx_en = 1'b1;
                    r_d.idx   = '0;
                    r_d.bit_n = '0;
                    r_d.shift = byte_sel;
                end
            end

            ST_SEND: begin
                if (bit_tick) begin
                    if (r_q.bit_n != 3'd7) begin
                        r_d.shift = {r_q.shift[6:0], 1'b0};
                        r_d.bit_n = r_q.bit_n + 3'd1;
                    end else if (r_q.idx == last_idx) begin
                        r_d.st    = ST_IDLE;
                        r_d.tx_en = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.shift = '0;
                    end else begin
                        r_d.idx   = ld_idx;
                        r_d.bit_n = '0;
                        r_d.shift = byte_sel;
                        if (ld_idx == IDX_W'(2) || ld_is_data) begin
                            r_d.crc = crc_next;
                        end
                        if (ld_needs_rd) begin
                            r_d.rd_en   = 1'b1;
                            r_d.rd_addr = ADDR_W'(ld_idx - IDX_W'(HDR_N - 1));
                        end
                    end
                end
            end

            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_en_o   = r_q.rd_en;
    assign rd_addr_o = r_q.rd_addr;
    assign sout_o    = r_q.shift[7];
    assign tx_en_o   = r_q.tx_en;
    assign done_o    = r_q.done;

endmodule

// File: rtl/ptx_frame_tx_chk.sv
module ptx_frame_tx_chk #(
    parameter int unsigned MAX_LEN = 124,
    parameter int unsigned ADDR_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en_i,
    input logic              done_i,
    input logic              sout_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic              tick_i
);

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);  // R8

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en_i) |-> done_i);  // R8

    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (!tx_en_i && $past(tx_en_i)));  // R8

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |-> !sout_i);  // R8

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_i && $past(tx_en_i) && !$past(tick_i)) |-> $stable(sout_i));  // R4

    AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |-> (tx_en_i && (int'(rd_addr_i) < MAX_LEN)));  // R7

endmodule

bind ptx_frame_tx ptx_frame_tx_chk #(
    .MAX_LEN (MAX_LEN),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en_i   (tx_en_o),
    .done_i    (done_o),
    .sout_i    (sout_o),
    .rd_en_i   (rd_en_o),
    .rd_addr_i (rd_addr_o),
    .tick_i    (bit_tick)
);

// File: tb/tb_ptx_frame_tx.sv
`timescale 1ns/1ps
module tb_ptx_frame_tx;

    localparam int TA    = 40;
    localparam int DSLOW = 160;
    localparam int DMID  = 5;
    localparam int DFAST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] rate_i = 2'd0;
    logic [6:0] len_i = 7'd0;
    logic       rd_en_o;
    logic [6:0] rd_addr_o;
    logic [7:0] rd_data_i = 8'h00;
    logic       sout_o, tx_en_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mem [0:127];
    int         rlog [0:255];
    int         nlog = 0;

    always #2 clk = ~clk;

    ptx_frame_tx #(
        .TA_CYCLES (TA),
        .DIV_SLOW  (DSLOW),
        .DIV_MID   (DMID),
        .DIV_FAST  (DFAST)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rate_i    (rate_i),
        .len_i     (len_i),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .sout_o    (sout_o),
        .tx_en_o   (tx_en_o),
        .done_o    (done_o)
    );

    // produce buffer model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (rd_en_o) begin
            rd_data_i <= mem[rd_addr_o];
            if (nlog < 256) rlog[nlog] = int'(rd_addr_o);
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int div_of(input int rate);
        if (rate == 1) return DMID;
        if (rate == 2) return DFAST;
        return DSLOW;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        x = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) begin
            if (x[15]) x = (x << 1) ^ 16'h1021;
            else       x = x << 1;
        end
        return x;
    endfunction

    task automatic test_reset();
        chk(!tx_en_o, "R10", "tx_en after reset", int'(tx_en_o), 0);
        chk(!sout_o,  "R10", "sout after reset",  int'(sout_o), 0);
        chk(!done_o,  "R10", "done after reset",  int'(done_o), 0);
        chk(!rd_en_o, "R10", "rd_en after reset", int'(rd_en_o), 0);
    endtask

    task automatic send_frame(input int rate, input int len, input bit poke);
        logic [7:0]  exp_b [0:129];
        logic [7:0]  got_b [0:129];
        logic [15:0] crc;
        int nbytes, div, cnt, c, nb, bad_hdr, bad_pay, extra_done;
        bit seen;

        nbytes = len + 6;
        div    = div_of(rate);
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + len * 11 + rate * 5 + 3) & 255);
        exp_b[0] = 8'hA9;
        exp_b[1] = 8'h6E;
        exp_b[2] = 8'h50;
        crc = crc_step(16'hFFFF, 8'h50);
        for (int i = 0; i < len; i++) begin
            exp_b[3 + i] = mem[i];
            crc = crc_step(crc, mem[i]);
        end
        exp_b[len + 3] = crc[15:8];
        exp_b[len + 4] = crc[7:0];
        exp_b[len + 5] = 8'hD4;
        for (int i = 0; i < 130; i++) got_b[i] = 8'h00;
        nlog = 0;

        @(negedge clk);
        start_i = 1'b1; rate_i = 2'(rate); len_i = 7'(len);
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!tx_en_o && cnt <= TA + 5) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == TA + 1, "R3", "turnaround cycles", cnt - 1, TA);

        c = 0; nb = 0;
        while (tx_en_o && c < 140 * 8 * DSLOW) begin
            if ((c % div) == div / 2) begin
                if (nb < 130 * 8) got_b[nb / 8] = {got_b[nb / 8][6:0], sout_o};
                nb++;
            end
            if (poke && c == 30) begin
                start_i = 1'b1; rate_i = 2'd2; len_i = 7'd3;
            end
            if (poke && c == 31) start_i = 1'b0;
            @(negedge clk);
            c++;
        end
        chk(c == nbytes * 8 * div, "R4", "tx_en high cycles", c, nbytes * 8 * div);
        chk(done_o == 1'b1, "R8", "done as tx_en falls", int'(done_o), 1);
        chk(sout_o == 1'b0, "R8", "line low after frame", int'(sout_o), 0);

        bad_hdr = 0; bad_pay = 0;
        for (int i = 0; i < 3; i++) if (got_b[i] !== exp_b[i]) bad_hdr++;
        if (got_b[len + 5] !== exp_b[len + 5]) bad_hdr++;
        for (int i = 3; i < len + 3; i++) if (got_b[i] !== exp_b[i]) bad_pay++;
        chk(bad_hdr == 0, "R1", "fixed field bytes wrong", bad_hdr, 0);
        chk(bad_pay == 0, "R7", "payload bytes wrong", bad_pay, 0);
        chk({got_b[len + 3], got_b[len + 4]} === crc, "R6", "crc",
            int'({got_b[len + 3], got_b[len + 4]}), int'(crc));

        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done one clock", int'(done_o), 0);

        seen = (nlog == len);
        for (int i = 0; i < len && i < 256; i++) if (rlog[i] != i) seen = 1'b0;
        chk(seen, "R7", "read sequence count", nlog, len);

        if (poke) begin
            seen = 1'b0; extra_done = 0;
            for (int i = 0; i < TA + 40; i++) begin
                @(negedge clk);
                if (tx_en_o) seen = 1'b1;
                if (done_o) extra_done++;
            end
            chk(!seen && extra_done == 0, "R9", "start while busy acted",
                int'(seen) + extra_done, 0);
        end
    endtask

    task automatic try_ignored(input int rate, input int len, input string req);
        int act;
        act = 0;
        nlog = 0;
        @(negedge clk);
        start_i = 1'b1; rate_i = 2'(rate); len_i = 7'(len);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < TA + 40; i++) begin
            if (tx_en_o || done_o) act++;
            @(negedge clk);
        end
        act += nlog;
        chk(act == 0, req, $sformatf("start rate %0d len %0d not ignored", rate, len), act, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        send_frame(1, 2, 1'b0);      // R1 R6 shortest legal payload, middle rate
        send_frame(2, 124, 1'b0);    // R2 longest payload, fast rate
        send_frame(0, 2, 1'b0);      // R4 slow rate
        send_frame(1, 17, 1'b1);     // R9 start during a frame
        try_ignored(1, 1, "R2");
        try_ignored(2, 125, "R2");
        try_ignored(1, 0, "R2");
        try_ignored(3, 10, "R5");
        send_frame(2, 5, 1'b0);      // recovers after ignored starts
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule